// File: doc/BRIEF.md
# Shared-Buffer Multicast Packet Switch

This block is a single-stage, self-routing crossbar for fixed-length packets. Every input presents one whole packet at a time. A packet is a header word plus a payload of `PKT_WORDS` data words. The header names the set of destination outputs as a bitmap and carries a priority and an even-parity bit. A round-robin arbiter picks one input per cycle. The winning payload is written once into a pool of `NBUF` shared buffers, and the buffer's index is queued at every output the bitmap selects.

Each buffer has a reference count loaded with the number of destinations. Every output that finishes sending the buffer decrements the count. The buffer goes back to the pool when the last copy leaves, so a multicast never duplicates payload storage. Each output keeps one index queue per priority and always drains the most urgent non-empty one.

Senders are throttled through one grant line per priority. Each grant compares the number of free buffers against a programmable threshold for that priority. Packets whose header fails parity, or that name no output at all, are taken from the input and thrown away. They are counted and consume no buffer.

Top module: `sw_mcast_switch`

## Requirements
- R1: After reset no output is valid, the error count is zero and all `NBUF` buffers are free.
- R2: A header is `DATA_W` bits. Bits [NPORTS-1:0] are the destination bitmap, with bit o selecting output o. Bits [NPORTS+1:NPORTS] are the priority. Bit DATA_W-1 is the parity bit, which makes the XOR of all header bits zero. An accepted good packet appears on exactly the outputs in its bitmap, with its payload unchanged. `in_accept` is asserted only for an input that is presenting a packet.
- R3: An accepted good packet takes exactly one buffer, whatever the number of outputs in its bitmap.
- R4: A buffer returns to the pool only in the cycle after the last selected output has sent it. An output that is presenting a packet keeps `out_valid` high until `out_ready` takes it.
- R5: A packet whose header parity is wrong is accepted and dropped, and it raises the error count by one. It takes no buffer and reaches no output.
- R6: A packet with an all-zero bitmap is handled the same way as in R5.
- R7: An output presents priority 0 (most urgent) before priority 1, and so on down, whenever several of its queues hold packets.
- R8: Within one priority, an output sends packets in the order they were accepted.
- R9: `grant[p]` is high exactly when the number of free buffers is at least `thr[p]`.
- R10: When several inputs request in consecutive cycles, acceptance rotates in round-robin order: each winner is the next requesting input after the previous winner.
- R11: A priority field of `NPRIO` or more is treated as priority `NPRIO-1`, and `out_prio` reports that value.
- R12: With no free buffer, a good packet is held (not accepted) until a buffer is released. A bad packet is still accepted and dropped in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Input i presents a packet |
| in_hdr | input | NPORTS*DATA_W | Header word for each input |
| in_payload | input | NPORTS*PKT_WORDS*DATA_W | Payload for each input |
| in_accept | output | NPORTS | Packet on input i is taken at this edge |
| thr | input | NPRIO*CNT_W | Free-buffer threshold for each priority |
| grant | output | NPRIO | Sending of priority p is allowed |
| out_valid | output | NPORTS | Output o presents a packet |
| out_ready | input | NPORTS | Output o takes its packet at this edge |
| out_payload | output | NPORTS*PKT_WORDS*DATA_W | Payload presented by each output |
| out_prio | output | NPORTS*2 | Effective priority of each presented packet |
| err_count | output | ERR_W | Saturating count of dropped bad packets |

## Verification
The hardest state to reach is a completely empty buffer pool while a good packet and a bad packet are both waiting. The bench holds every output stalled and steers packets to one output until all buffers are taken. It sweeps every threshold value against the grant lines at each fill level along the way, which also reads back the free count through the ports. With the pool empty it shows the good packet being held while the bad one is still dropped. It then releases a single buffer and watches the held packet go through.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
   localparam int HDR_PRIO_W = 2;

   function automatic int unsigned count_ones(input logic [63:0] v);
      int unsigned n;
      n = 0;
      for (int k = 0; k < 64; k++) n += int'(v[k]);
      return n;
   endfunction
endpackage

// File: rtl/sw_rr_arb.sv
`timescale 1ns/1ps
module sw_rr_arb #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] gnt_idx,
   output logic          any
);
   logic [IW-1:0] start;

   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      any     = 1'b0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(start) + k) % N;
         if (!any && req[j]) begin
            any     = 1'b1;
            gnt[j]  = 1'b1;
            gnt_idx = IW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) start <= '0;
      else if (any) start <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
   end
endmodule

// File: rtl/sw_ptr_fifo.sv
`timescale 1ns/1ps
module sw_ptr_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 3,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty
);
   logic [W-1:0]  slot [DEPTH];
   logic [AW-1:0] rd, wr;
   logic [CW-1:0] cnt;
   logic          do_pop;

   assign empty  = (cnt == '0);
   assign head   = slot[rd];
   assign do_pop = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd  <= '0;
         wr  <= '0;
         cnt <= '0;
      end else begin
         if (push) begin
            slot[wr] <= push_data;
            wr <= (wr == AW'(DEPTH - 1)) ? '0 : wr + 1'b1;
         end
         if (do_pop) rd <= (rd == AW'(DEPTH - 1)) ? '0 : rd + 1'b1;
         cnt <= cnt + CW'(push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/sw_buf_pool.sv
`timescale 1ns/1ps
module sw_buf_pool #(
   parameter int NBUF   = 8,
   parameter int NPORTS = 4,
   localparam int IW    = $clog2(NBUF),
   localparam int RW    = $clog2(NPORTS + 1),
   localparam int CW    = $clog2(NBUF + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_en,
   input  logic [RW-1:0]        alloc_refs,
   input  logic [NPORTS-1:0]    rel_en,
   input  logic [NPORTS*IW-1:0] rel_idx,
   output logic [IW-1:0]        alloc_idx,
   output logic                 have_free,
   output logic [CW-1:0]        free_count
);
   logic [NBUF-1:0] busy;
   logic [RW-1:0]   refcnt [NBUF];
   logic [RW-1:0]   dec    [NBUF];

   always_comb begin
      alloc_idx = '0;
      have_free = 1'b0;
      for (int b = NBUF - 1; b >= 0; b--) begin
         if (!busy[b]) begin
            alloc_idx = IW'(b);
            have_free = 1'b1;
         end
      end
   end

   always_comb begin
      free_count = '0;
      for (int b = 0; b < NBUF; b++) free_count = free_count + CW'(!busy[b]);
   end

   always_comb begin
      for (int b = 0; b < NBUF; b++) begin
         dec[b] = '0;
         for (int p = 0; p < NPORTS; p++)
            if (rel_en[p] && rel_idx[p*IW +: IW] == IW'(b)) dec[b] = dec[b] + RW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= '0;
         for (int b = 0; b < NBUF; b++) refcnt[b] <= '0;
      end else begin
         for (int b = 0; b < NBUF; b++) begin
            if (alloc_en && alloc_idx == IW'(b)) begin
               busy[b]   <= 1'b1;
               refcnt[b] <= alloc_refs;
            end else if (busy[b] && dec[b] != '0) begin
               refcnt[b] <= refcnt[b] - dec[b];
               if (refcnt[b] == dec[b]) busy[b] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/sw_mcast_switch.sv
`timescale 1ns/1ps
module sw_mcast_switch #(
   parameter int NPORTS    = 4,
   parameter int NPRIO     = 2,
   parameter int NBUF      = 8,
   parameter int DATA_W    = 8,
   parameter int PKT_WORDS = 4,
   parameter int ERR_W     = 8,
   localparam int PKT_BITS = PKT_WORDS * DATA_W,
   localparam int CNT_W    = $clog2(NBUF + 1),
   localparam int PW       = sw_pkg::HDR_PRIO_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPORTS-1:0]           in_valid,
   input  logic [NPORTS*DATA_W-1:0]    in_hdr,
   input  logic [NPORTS*PKT_BITS-1:0]  in_payload,
   output logic [NPORTS-1:0]           in_accept,
   input  logic [NPRIO*CNT_W-1:0]      thr,
   output logic [NPRIO-1:0]            grant,
   output logic [NPORTS-1:0]           out_valid,
   input  logic [NPORTS-1:0]           out_ready,
   output logic [NPORTS*PKT_BITS-1:0]  out_payload,
   output logic [NPORTS*PW-1:0]        out_prio,
   output logic [ERR_W-1:0]            err_count
);
   localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
   localparam int BIDX_W = $clog2(NBUF);
   localparam int REF_W  = $clog2(NPORTS + 1);

   // elaboration-time parameter checks
   if (NPRIO < 1 || NPRIO > 4) begin : g_bad_prio
      $error("NPRIO must lie in 1..4");
   end
   if (NPORTS < 2 || NPORTS > 32 || NPORTS + PW + 1 > DATA_W) begin : g_bad_ports
      $error("NPORTS must be 2..32 and fit the header word with priority and parity");
   end
   if (NBUF < 2) begin : g_bad_nbuf
      $error("NBUF must be at least 2");
   end
   if (PKT_WORDS < 1 || ERR_W < 1) begin : g_bad_len
      $error("PKT_WORDS and ERR_W must be positive");
   end

   // header decode per input
   logic [NPORTS-1:0] hb  [NPORTS];
   logic [PW-1:0]     hp  [NPORTS];
   logic [NPORTS-1:0] bad;

   for (genvar i = 0; i < NPORTS; i++) begin : g_hdr
      logic [DATA_W-1:0] h;
      logic [PW-1:0]     praw;
      assign h     = in_hdr[i*DATA_W +: DATA_W];
      assign hb[i] = h[NPORTS-1:0];
      assign praw  = h[NPORTS +: PW];
      assign hp[i] = (int'(praw) >= NPRIO) ? PW'(NPRIO - 1) : praw;
      assign bad[i] = (^h) || (h[NPORTS-1:0] == '0);
   end

   // buffer pool
   logic [BIDX_W-1:0]        alloc_idx;
   logic                     have_free;
   logic [CNT_W-1:0]         free_count;
   logic [NPORTS-1:0]        rel_en;
   logic [NPORTS*BIDX_W-1:0] rel_idx;
   logic                     good_wr;
   logic [REF_W-1:0]         alloc_refs;

   // input arbitration
   logic [NPORTS-1:0] req;
   logic [PIDX_W-1:0] win_idx;
   logic              win_any;
   logic [NPORTS-1:0] wb;
   logic [PW-1:0]     wp;

   assign req = in_valid & (bad | {NPORTS{have_free}});

   sw_rr_arb #(.N(NPORTS)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .gnt     (in_accept),
      .gnt_idx (win_idx),
      .any     (win_any)
   );

   assign wb         = hb[win_idx];
   assign wp         = hp[win_idx];
   assign good_wr    = win_any && !bad[win_idx];
   assign alloc_refs = REF_W'(sw_pkg::count_ones(64'(wb)));

   sw_buf_pool #(.NBUF(NBUF), .NPORTS(NPORTS)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (good_wr),
      .alloc_refs (alloc_refs),
      .rel_en     (rel_en),
      .rel_idx    (rel_idx),
      .alloc_idx  (alloc_idx),
      .have_free  (have_free),
      .free_count (free_count)
   );

   // shared payload storage, written once per good packet
   logic [PKT_BITS-1:0] mem [NBUF];

   always_ff @(posedge clk) begin
      if (good_wr) mem[alloc_idx] <= in_payload[win_idx*PKT_BITS +: PKT_BITS];
   end

   // dropped-packet counter, saturating
   always_ff @(posedge clk) begin
      if (!rst_n) err_count <= '0;
      else if (win_any && bad[win_idx] && err_count != '1) err_count <= err_count + 1'b1;
   end

   // grant per priority
   for (genvar p = 0; p < NPRIO; p++) begin : g_grant
      assign grant[p] = (free_count >= thr[p*CNT_W +: CNT_W]);
   end

   // output side: one queue per priority, strict priority selection
   for (genvar o = 0; o < NPORTS; o++) begin : g_out
      logic [NPRIO-1:0]  emp;
      logic [BIDX_W-1:0] hd [NPRIO];
      logic [PW-1:0]     sel;
      logic              found;
      logic [BIDX_W-1:0] head_o;

      for (genvar p = 0; p < NPRIO; p++) begin : g_q
         logic push_q, pop_q;
         assign push_q = good_wr && wb[o] && (wp == PW'(p));
         assign pop_q  = rel_en[o] && (sel == PW'(p));
         sw_ptr_fifo #(.DEPTH(NBUF), .W(BIDX_W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_q),
            .push_data (alloc_idx),
            .pop       (pop_q),
            .head      (hd[p]),
            .empty     (emp[p])
         );
      end

      always_comb begin
         sel   = '0;
         found = 1'b0;
         for (int p = 0; p < NPRIO; p++) begin
            if (!found && !emp[p]) begin
               sel   = PW'(p);
               found = 1'b1;
            end
         end
      end

      assign head_o                         = hd[sel];
      assign out_valid[o]                   = found;
      assign rel_en[o]                      = found && out_ready[o];
      assign rel_idx[o*BIDX_W +: BIDX_W]    = head_o;
      assign out_payload[o*PKT_BITS +: PKT_BITS] = mem[head_o];
      assign out_prio[o*PW +: PW]           = sel;
   end
endmodule

// File: rtl/sw_mcast_switch_chk.sv
`timescale 1ns/1ps
module sw_mcast_switch_chk #(
   parameter int NPORTS = 4,
   parameter int ERR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORTS-1:0] in_valid,
   input logic [NPORTS-1:0] in_accept,
   input logic [NPORTS-1:0] out_valid,
   input logic [NPORTS-1:0] out_ready,
   input logic [ERR_W-1:0]  err_count
);
   // R1: clean state right after reset release
   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_valid == '0 && err_count == '0));

   // R10: at most one input taken per cycle
   assert_single_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_accept));

   // R5 / R6: the drop counter moves by at most one per cycle
   assert_err_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count - $past(err_count)) <= ERR_W'(1));

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      // R2: an input is only taken when it offers a packet
      assert_accept_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
         in_accept[i] |-> in_valid[i]);

      // R4: a stalled output keeps its packet
      assert_stall_keeps_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[i] && !out_ready[i]) |=> out_valid[i]);
   end
endmodule

bind sw_mcast_switch sw_mcast_switch_chk #(.NPORTS(NPORTS), .ERR_W(ERR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_accept (in_accept),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .err_count (err_count)
);

// File: tb/test_sw_mcast_switch.sv
`timescale 1ns/1ps
module test_sw_mcast_switch;
   localparam int NP = 4, NPR = 2, NB = 8, DW = 8, PWD = 4, EW = 8;
   localparam int PB = PWD * DW;
   localparam int CW = $clog2(NB + 1);
   localparam real CLK_NS = 8.0;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NP-1:0]        in_valid = '0;
   logic [NP*DW-1:0]     in_hdr = '0;
   logic [NP*PB-1:0]     in_payload = '0;
   logic [NP-1:0]        in_accept;
   logic [NPR*CW-1:0]    thr = '0;
   logic [NPR-1:0]       grant;
   logic [NP-1:0]        out_valid;
   logic [NP-1:0]        out_ready = '0;
   logic [NP*PB-1:0]     out_payload;
   logic [NP*2-1:0]      out_prio;
   logic [EW-1:0]        err_count;

   int n_checks = 0, n_fail = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sw_mcast_switch #(.NPORTS(NP), .NPRIO(NPR), .NBUF(NB), .DATA_W(DW),
                     .PKT_WORDS(PWD), .ERR_W(EW)) i_sw_mcast_switch (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
      .in_payload(in_payload), .in_accept(in_accept), .thr(thr), .grant(grant),
      .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
      .out_prio(out_prio), .err_count(err_count));

   task automatic chk(input string rq, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mk_hdr(input int bmap, input int prio, input bit corrupt);
      logic [DW-1:0] h;
      h = '0;
      h[NP-1:0]  = NP'(bmap);
      h[NP +: 2] = 2'(prio);
      h[DW-1]    = ^h[DW-2:0];
      if (corrupt) h[DW-1] = ~h[DW-1];
      return h;
   endfunction

   function automatic logic [PB-1:0] mk_pl(input int k);
      return {8'(k), 8'(k ^ 8'h5A), 8'(k + 3), 8'hC3};
   endfunction

   // reads the free-buffer count back through the priority-0 threshold
   task automatic probe_free(output int f);
      logic [CW-1:0] saved;
      saved = thr[CW-1:0];
      f = -1;
      for (int t = 0; t <= NB; t++) begin
         thr[CW-1:0] = CW'(t);
         #0.1;
         if (grant[0]) f = t;
      end
      thr[CW-1:0] = saved;
      #0.1;
   endtask

   task automatic send(input int port, input logic [DW-1:0] h, input logic [PB-1:0] pl);
      @(negedge clk);
      in_hdr[port*DW +: DW]     = h;
      in_payload[port*PB +: PB] = pl;
      in_valid[port]            = 1'b1;
      for (int w = 0; w < 50; w++) begin
         #1;
         if (in_accept[port]) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1;
      in_valid[port] = 1'b0;
   endtask

   task automatic pop(input logic [NP-1:0] m);
      @(negedge clk);
      out_ready = m;
      @(posedge clk);
      #1;
      out_ready = '0;
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int f, e0;
      int wins [8];
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1
      chk("R1 out_valid", out_valid, 0);
      chk("R1 err_count", err_count, 0);
      probe_free(f);
      chk("R1 free", f, NB);

      // R2 / R3: every non-empty bitmap
      for (int b = 1; b < (1 << NP); b++) begin
         send(b % NP, mk_hdr(b, 0, 1'b0), mk_pl(b));
         chk("R2 out_valid set", out_valid, b);
         for (int o = 0; o < NP; o++)
            if (b[o]) begin
               chk("R2 payload", out_payload[o*PB +: PB], mk_pl(b));
               chk("R2 prio", out_prio[o*2 +: 2], 0);
            end
         probe_free(f);
         chk("R3 one buffer per packet", f, NB - 1);
         pop('1);
         chk("R4 all sent", out_valid, 0);
         probe_free(f);
         chk("R4 buffer back", f, NB);
      end

      // R4: buffer held until last copy leaves
      send(3, mk_hdr(15, 1, 1'b0), mk_pl(77));
      for (int o = 0; o < NP; o++) begin
         pop(NP'(1 << o));
         probe_free(f);
         chk("R4 free after partial send", f, (o == NP - 1) ? NB : NB - 1);
         chk("R4 remaining outputs", out_valid, (15 >> (o + 1)) << (o + 1));
      end

      // R5: parity error
      e0 = err_count;
      send(1, mk_hdr(5, 0, 1'b1), mk_pl(9));
      chk("R5 err_count", err_count, e0 + 1);
      chk("R5 no output", out_valid, 0);
      probe_free(f);
      chk("R5 no buffer", f, NB);

      // R6: empty bitmap
      send(2, mk_hdr(0, 0, 1'b0), mk_pl(10));
      chk("R6 err_count", err_count, e0 + 2);
      chk("R6 no output", out_valid, 0);
      probe_free(f);
      chk("R6 no buffer", f, NB);

      // R7 / R8 / R11: ordering on output 2
      send(0, mk_hdr(4, 1, 1'b0), mk_pl(20));
      send(1, mk_hdr(4, 1, 1'b0), mk_pl(21));
      send(2, mk_hdr(4, 0, 1'b0), mk_pl(22));
      send(3, mk_hdr(4, 3, 1'b0), mk_pl(23));
      begin
         int exp_k [4] = '{22, 20, 21, 23};
         int exp_p [4] = '{0, 1, 1, 1};
         for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            chk("R7 valid", out_valid[2], 1);
            chk((n == 0) ? "R7 urgent first" : "R8 fifo order",
                out_payload[2*PB +: PB], mk_pl(exp_k[n]));
            chk((n == 3) ? "R11 clamped prio" : "R7 prio", out_prio[4 +: 2], exp_p[n]);
            pop(4'b0100);
         end
         chk("R8 drained", out_valid, 0);
      end

      // R9: threshold sweep at every fill level
      for (int k = 0; k <= NB; k++) begin
         @(negedge clk);
         for (int t = 0; t <= NB + 1; t++) begin
            thr[CW +: CW] = CW'(t);
            #0.1;
            chk("R9 grant vs threshold", grant[1], ((NB - k) >= t) ? 1 : 0);
         end
         thr[CW +: CW] = '0;
         if (k < NB) send(k % NP, mk_hdr(1, 0, 1'b0), mk_pl(40 + k));
      end

      // R12: pool empty
      @(negedge clk);
      in_hdr[1*DW +: DW]   = mk_hdr(2, 0, 1'b0);
      in_payload[1*PB +: PB] = mk_pl(60);
      in_valid[1]          = 1'b1;
      for (int n = 0; n < 3; n++) begin
         #1;
         chk("R12 good packet held", in_accept, 0);
         @(negedge clk);
      end
      e0 = err_count;
      in_hdr[2*DW +: DW] = mk_hdr(3, 0, 1'b1);
      in_valid[2]        = 1'b1;
      #1;
      chk("R12 bad packet still taken", in_accept, 4'b0100);
      @(posedge clk);
      #1 in_valid[2] = 1'b0;
      chk("R12 bad counted", err_count, e0 + 1);
      pop(4'b0001);
      @(negedge clk);
      #1;
      chk("R12 accepted after release", in_accept, 4'b0010);
      @(posedge clk);
      #1 in_valid[1] = 1'b0;
      chk("R12 delivered", out_valid[1], 1);
      chk("R12 payload", out_payload[1*PB +: PB], mk_pl(60));
      for (int n = 0; n < 12 && out_valid != 0; n++) pop('1);
      probe_free(f);
      chk("R4 pool refilled", f, NB);

      // R10: all inputs request continuously
      @(negedge clk);
      out_ready = '1;
      for (int i = 0; i < NP; i++) begin
         in_hdr[i*DW +: DW]     = mk_hdr(15, 0, 1'b0);
         in_payload[i*PB +: PB] = mk_pl(80 + i);
      end
      in_valid = '1;
      for (int n = 0; n < 8; n++) begin
         #1;
         chk("R10 one winner", $countones(in_accept), 1);
         wins[n] = 0;
         for (int i = 0; i < NP; i++) if (in_accept[i]) wins[n] = i;
         @(negedge clk);
      end
      in_valid = '0;
      for (int n = 1; n < 8; n++)
         chk("R10 rotation", wins[n], (wins[n-1] + 1) % NP);
      repeat (3) @(negedge clk);
      out_ready = '0;
      chk("R10 drained", out_valid, 0);
      probe_free(f);
      chk("R10 pool refilled", f, NB);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule